// File: doc/BRIEF.md
# Time-Shared Serial DAC Output Formatter

This block turns a stream of left/right sample pairs, already at four times the base sample rate, into one serial bit stream for a single DAC that alternates between channels. Each oversampled period carries the left word, a run of zero bits, the right word and another run of zeros. The block also drives the serial bit clock and two deglitch strobes, one per channel. A downstream converter, or a pair of converters behind a little external gating, uses these strobes to pick the settled output of each channel.

The block runs from a core clock at twice the bit rate. The bit clock toggles on every core cycle, and all outputs change only on its rising edge. The rate-select input chooses 48 bit clocks per oversampled period when high (192x base rate) or 49 when low (196x base rate). The new length is taken up only when a period begins. A sample pair arrives with a one-cycle valid strobe. It is held and sent in the next period, and it repeats until a newer pair replaces it.

Top module: `serial_dac_fmt`

## Requirements
- R1: While reset is high, and until the first rising edge of the bit clock after reset, bclk_out, sdata_out, deg_l_out and deg_r_out are all low. The first period after reset carries all-zero words.
- R2: After the first bit clock rise, bclk_out inverts on every core clock cycle, so one bit slot lasts two core cycles.
- R3: A period lasts 48 bit slots when rate_sel was high, and 49 bit slots when it was low, at the edge that began the period.
- R4: A change of rate_sel in the middle of a period does not alter that period's length.
- R5: sdata_out changes only on the core edge where bclk_out rises. It is constant while bclk_out is low.
- R6: Slots 0 to 15 of a period carry the left word in two's complement as received, with bit 15 in slot 0 and bit 0 in slot 15.
- R7: Slots 24 to 39 carry the right word in the same way, with bit 15 in slot 24.
- R8: Slots 16 to 23, and slots 40 to the end of the period, carry 0.
- R9: deg_l_out is high in slots 16 to 27 (12 slots, one quarter of a 48-slot period) and low in all other slots.
- R10: deg_r_out is high in slot 40 up to the end of the period and in slots 0 to 3. It is low in slots 4 to 39.
- R11: A pair taken with pair_valid is sent in the next period that begins after it, and is sent again in every later period until another pair is taken. If several pairs arrive in one period, the last one is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | 1: 48 slots per period, 0: 49 slots per period |
| pair_valid | input | 1 | Takes left_in/right_in on this cycle |
| left_in | input | 16 | Left sample, two's complement |
| right_in | input | 16 | Right sample, two's complement |
| bclk_out | output | 1 | Serial bit clock |
| sdata_out | output | 1 | Serial data, MSB first, left then right |
| deg_l_out | output | 1 | Left channel deglitch strobe |
| deg_r_out | output | 1 | Right channel deglitch strobe |

## Verification
Random pairs arrive at random times against a slot-accurate model. This separates correct bit order and channel placement from swapped halves or shifted slots. Directed pairs of full-scale positive, full-scale negative, -1 and +1 expose MSB or sign mistakes that random data can hide. A phase with no valid strobes tells a held pair apart from one that is cleared or reloaded. A phase that toggles rate_sel in the middle of periods checks that the period length follows only the value seen at each period start. The gap between deglitch strobes is measured to confirm the 48 or 49 slot period length.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    localparam int DEF_WORD_W     = 16;
    localparam int DEF_FRAME_BASE = 48;

    typedef enum logic {
        RATE_196 = 1'b0,
        RATE_192 = 1'b1
    } rate_mode_e;

    // true when slot s lies in [lo, lo+len) taken modulo base; wraps past base
    function automatic logic in_window(int s, int lo, int len, int base);
        int hi;
        hi = lo + len;
        if (hi <= base)
            return (s >= lo) && (s < hi);
        else
            return (s >= lo) || (s < hi - base);
    endfunction

endpackage

// File: rtl/sdf_slot_timer.sv
module sdf_slot_timer
    import sdf_pkg::*;
#(
    parameter int FRAME_BASE = DEF_FRAME_BASE,
    parameter int SLOT_W     = $clog2(FRAME_BASE + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  rate_mode_e        rate,
    output logic              bclk,
    output logic              live,
    output logic [SLOT_W-1:0] slot,
    output logic              load_now
);
    localparam logic [SLOT_W-1:0] LEN_SHORT = SLOT_W'(FRAME_BASE);
    localparam logic [SLOT_W-1:0] LEN_LONG  = SLOT_W'(FRAME_BASE + 1);
    localparam logic [SLOT_W-1:0] ONE       = SLOT_W'(1);

    logic [SLOT_W-1:0] len_q;
    logic              at_last;

    assign at_last  = (slot == len_q - ONE);
    // a period begins on the edge where bclk rises from the last slot
    assign load_now = !bclk && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk  <= 1'b0;
            live  <= 1'b0;
            slot  <= LEN_SHORT - ONE;
            len_q <= LEN_SHORT;
        end else begin
            bclk <= ~bclk;
            if (!bclk) begin
                live <= 1'b1;
                if (at_last) begin
                    slot  <= '0;
                    len_q <= (rate == RATE_192) ? LEN_SHORT : LEN_LONG;
                end else begin
                    slot <= slot + ONE;
                end
            end
        end
    end

    // R2: bit clock inverts every core cycle once running
    p_bclk_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && live) |-> (bclk != $past(bclk)));

    // R3: slot index stays inside the current period length
    p_slot_range_r3: assert property (@(posedge clk) disable iff (rst)
        slot < len_q);

    // R4: period length only moves when a period starts
    p_len_boundary_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && slot != '0) |-> $stable(len_q));

endmodule

// File: rtl/sdf_pair_hold.sv
module sdf_pair_hold #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [WORD_W-1:0] left_in,
    input  logic [WORD_W-1:0] right_in,
    input  logic              load_now,
    output logic [WORD_W-1:0] left_act,
    output logic [WORD_W-1:0] right_act
);
    typedef struct packed {
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
    } pair_t;

    pair_t pend_q, act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (load_now) act_q  <= pend_q;
            if (take)     pend_q <= '{left: left_in, right: right_in};
        end
    end

    assign left_act  = act_q.left;
    assign right_act = act_q.right;

    // R11: the words being sent only move at a period start
    p_act_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !load_now |=> $stable(act_q));

endmodule

// File: rtl/sdf_serializer.sv
module sdf_serializer
    import sdf_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int FRAME_BASE = 48,
    parameter int SLOT_W     = 6
) (
    input  logic              live,
    input  logic [SLOT_W-1:0] slot,
    input  logic [WORD_W-1:0] left_act,
    input  logic [WORD_W-1:0] right_act,
    output logic              sdata,
    output logic              deg_l,
    output logic              deg_r
);
    localparam int HALF    = FRAME_BASE / 2;
    localparam int DEG_LEN = FRAME_BASE / 4;
    localparam int IDX_W   = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [SLOT_W-1:0] L_END   = SLOT_W'(WORD_W);
    localparam logic [SLOT_W-1:0] R_START = SLOT_W'(HALF);
    localparam logic [SLOT_W-1:0] R_END   = SLOT_W'(HALF + WORD_W);
    localparam logic [SLOT_W-1:0] MSB_POS = SLOT_W'(WORD_W - 1);

    logic [IDX_W-1:0] lidx, ridx;
    logic             bit_sel;

    assign lidx = IDX_W'(MSB_POS - slot);
    assign ridx = IDX_W'(MSB_POS - (slot - R_START));

    always_comb begin
        if (slot < L_END)
            bit_sel = left_act[lidx];
        else if (slot >= R_START && slot < R_END)
            bit_sel = right_act[ridx];
        else
            bit_sel = 1'b0;
    end

    assign sdata = live & bit_sel;

    // strobe windows: the right one may wrap into the next period
    generate
        if (HALF + WORD_W + DEG_LEN > FRAME_BASE) begin : g_wrap
            localparam logic [SLOT_W-1:0] WRAP_END = SLOT_W'(HALF + WORD_W + DEG_LEN - FRAME_BASE);
            assign deg_r = live & ((slot >= R_END) || (slot < WRAP_END));
        end else begin : g_flat
            assign deg_r = live & in_window(int'(slot), HALF + WORD_W, DEG_LEN, FRAME_BASE);
        end
    endgenerate

    assign deg_l = live & in_window(int'(slot), WORD_W, DEG_LEN, FRAME_BASE);

endmodule

// File: rtl/serial_dac_fmt.sv
module serial_dac_fmt
    import sdf_pkg::*;
#(
    parameter int WORD_W     = DEF_WORD_W,
    parameter int FRAME_BASE = DEF_FRAME_BASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_sel,
    input  logic              pair_valid,
    input  logic [WORD_W-1:0] left_in,
    input  logic [WORD_W-1:0] right_in,
    output logic              bclk_out,
    output logic              sdata_out,
    output logic              deg_l_out,
    output logic              deg_r_out
);
    localparam int SLOT_W = $clog2(FRAME_BASE + 2);
    localparam int HALF   = FRAME_BASE / 2;

    logic              live, load_now;
    logic [SLOT_W-1:0] slot;
    logic [WORD_W-1:0] left_act, right_act;
    rate_mode_e        rate;

    assign rate = rate_mode_e'(rate_sel);

    sdf_slot_timer #(.FRAME_BASE(FRAME_BASE), .SLOT_W(SLOT_W)) timer_i (
        .clk(clk), .rst(rst), .rate(rate), .bclk(bclk_out),
        .live(live), .slot(slot), .load_now(load_now)
    );

    sdf_pair_hold #(.WORD_W(WORD_W)) hold_i (
        .clk(clk), .rst(rst), .take(pair_valid),
        .left_in(left_in), .right_in(right_in), .load_now(load_now),
        .left_act(left_act), .right_act(right_act)
    );

    sdf_serializer #(.WORD_W(WORD_W), .FRAME_BASE(FRAME_BASE), .SLOT_W(SLOT_W)) ser_i (
        .live(live), .slot(slot), .left_act(left_act), .right_act(right_act),
        .sdata(sdata_out), .deg_l(deg_l_out), .deg_r(deg_r_out)
    );

    // R1: outputs quiet right after a reset edge
    p_quiet_reset_r1: assert property (@(posedge clk)
        rst |=> (!bclk_out && !sdata_out && !deg_l_out && !deg_r_out));

    // R5: serial data only moves with a rising bit clock
    p_data_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$rose(bclk_out)) |-> $stable(sdata_out));

    // R8: the gap after the left word carries zeros
    p_gap_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (int'(slot) >= WORD_W && int'(slot) < HALF) |-> !sdata_out);

    // R9 / R10: the two strobes never overlap
    p_deg_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(deg_l_out && deg_r_out));

endmodule

// File: tb/serial_dac_fmt_tb.sv
module serial_dac_fmt_tb_top;

    localparam int CLK_P = 10;
    localparam int W     = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rate_sel = 1'b1;
    logic         pair_valid = 1'b0;
    logic [W-1:0] left_in = '0;
    logic [W-1:0] right_in = '0;
    logic         bclk_out, sdata_out, deg_l_out, deg_r_out;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  done    = 0;
    bit  hold_ph = 0;

    always #(CLK_P/2) clk = ~clk;

    serial_dac_fmt dut_i (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .pair_valid(pair_valid),
        .left_in(left_in), .right_in(right_in), .bclk_out(bclk_out),
        .sdata_out(sdata_out), .deg_l_out(deg_l_out), .deg_r_out(deg_r_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_bit(int s, logic [W-1:0] l, logic [W-1:0] r);
        if (s < 16) return l[15 - s];
        if (s >= 24 && s < 40) return r[15 - (s - 24)];
        return 1'b0;
    endfunction

    function automatic bit exp_degl(int s);
        return (s >= 16) && (s < 28);
    endfunction

    function automatic bit exp_degr(int s);
        return (s >= 40) || (s < 4);
    endfunction

    // model state, sampled at falling core edges
    int           slot_e, len_e, since_rise, len_at_rise;
    bit           started, prev_bclk, last_sd, last_degl, have_rise;
    bit           mode_s, valid_s, mode_frame, chg_cur, chg_last, chg_at_rise;
    logic [W-1:0] l_s, r_s, pend_l, pend_r, act_l, act_r;
    string        tag;

    always @(negedge clk) begin
        if (rst) begin
            // R1: quiet during reset
            chk(!bclk_out && !sdata_out && !deg_l_out && !deg_r_out, "R1",
                {bclk_out, sdata_out, deg_l_out, deg_r_out}, 0);
            slot_e = 47; len_e = 48; started = 0; have_rise = 0;
            pend_l = '0; pend_r = '0; act_l = '0; act_r = '0;
            last_degl = 0; chg_cur = 0; chg_last = 0; since_rise = 0;
        end else begin
            if (started)
                chk(bclk_out != prev_bclk, "R2", bclk_out, !prev_bclk); // R2
            if (bclk_out && !prev_bclk) begin
                started = 1;
                if (slot_e == len_e - 1) begin
                    slot_e = 0;
                    len_e = mode_s ? 48 : 49;
                    mode_frame = mode_s;
                    act_l = pend_l; act_r = pend_r;
                    chg_last = chg_cur; chg_cur = 0;
                end else begin
                    slot_e++;
                end
                since_rise++;
                if (slot_e < 16)                    tag = hold_ph ? "R11" : "R6";
                else if (slot_e >= 24 && slot_e < 40) tag = hold_ph ? "R11" : "R7";
                else                                tag = "R8";
                chk(sdata_out == exp_bit(slot_e, act_l, act_r), tag, sdata_out,
                    exp_bit(slot_e, act_l, act_r));
                chk(deg_l_out == exp_degl(slot_e), "R9", deg_l_out, exp_degl(slot_e));
                chk(deg_r_out == exp_degr(slot_e), "R10", deg_r_out, exp_degr(slot_e));
                if (deg_l_out && !last_degl) begin
                    // R3 / R4: spacing of left strobes equals the previous period length
                    if (have_rise)
                        chk(since_rise == len_at_rise, chg_at_rise ? "R4" : "R3",
                            since_rise, len_at_rise);
                    have_rise = 1;
                    since_rise = 0;
                    len_at_rise = len_e;
                    chg_at_rise = chg_cur;
                end else if (deg_l_out && slot_e == 16) begin
                    chg_at_rise = chg_cur;
                end
                last_degl = deg_l_out;
                last_sd = sdata_out;
            end else if (started && !bclk_out) begin
                chk(sdata_out == last_sd, "R5", sdata_out, last_sd); // R5
            end
            if (valid_s) begin
                pend_l = l_s; pend_r = r_s;
            end
        end
        if (started && rate_sel != mode_frame) chg_cur = 1;
        prev_bclk = bclk_out;
        mode_s = rate_sel; valid_s = pair_valid; l_s = left_in; r_s = right_in;
    end

    task automatic push(input logic [W-1:0] l, input logic [W-1:0] r);
        @(posedge clk); #1;
        pair_valid = 1'b1; left_in = l; right_in = r;
        @(posedge clk); #1;
        pair_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (6) @(posedge clk);
        #1 rst = 1'b0;
        // first periods send zero words (R1)
        idle(200);
        // directed corner words (R6, R7)
        push(16'h8000, 16'h7FFF); idle(120);
        push(16'hFFFF, 16'h0001); idle(120);
        push(16'h0001, 16'h8000); idle(40);
        push(16'h1234, 16'hFFFF); idle(120); // last pair in a period wins (R11)
        // random traffic, occasional rate changes
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk); #1;
            pair_valid = ($urandom % 50) == 0;
            left_in    = W'($urandom);
            right_in   = W'($urandom);
            if (($urandom % 700) == 0) rate_sel = ~rate_sel;
        end
        pair_valid = 1'b0;
        rate_sel = 1'b1;
        idle(200);
        // hold phase: no new pairs (R11)
        push(16'hA5C3, 16'h5A3C); idle(120);
        hold_ph = 1; idle(600); hold_ph = 0;
        // mid-period rate changes (R4)
        for (int k = 0; k < 12; k++) begin
            idle(37 + k * 11);
            rate_sel = ~rate_sel;
        end
        rate_sel = 1'b0; idle(400);
        rate_sel = 1'b1; idle(400);
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog expired, actual 0 expected 1");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule